// File: doc/BRIEF.md
# Two-Bit Mealy State Machine

This block is a two-bit clocked state machine driven by one serial input bit. On every rising clock edge it moves to a new state, chosen by the present state and the input. It also drives one output bit that depends on both the present state and the input bit of the same cycle. The state bits leave the block on a port, so logic around it (or a bench) can follow the machine cycle by cycle.

The reset input is active low. Asserting it clears the state at once, without waiting for a clock edge. Releasing it takes effect through a short synchronizer, so the state register leaves reset on a clock edge. The transition rule is uneven. An input of 0 always sends the machine home to 00. An input of 1 climbs from 00 to 01 and then to 11. From either upper state, an input of 1 parks the machine at 10. The output is raised only when the machine is away from 00 and the input is 0, so it marks the cycle in which a run of ones breaks.

Top module: `mealy2_fsm`

## Requirements
- R1: While rst_n is low, state_out is 2'b00 with no clock edge needed. After rst_n rises, the state stays 2'b00 for the first SYNC_STAGES rising edges, whatever x_in is (default SYNC_STAGES = 2).
- R2: With x_in = 0 at a rising edge, the next state is 2'b00 from every present state.
- R3: With x_in = 1 at a rising edge and state 2'b00, the next state is 2'b01.
- R4: With x_in = 1 at a rising edge and state 2'b01, the next state is 2'b11.
- R5: With x_in = 1 at a rising edge and state 2'b10 or 2'b11, the next state is 2'b10.
- R6: With x_in = 1, y_out is 0 in every state.
- R7: With x_in = 0, y_out is 1 in states 2'b01, 2'b10 and 2'b11, and 0 in state 2'b00.
- R8: y_out has no register stage. It follows a change of x_in within the same clock cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset: asserts at once, releases through a synchronizer |
| x_in | input | 1 | Serial input bit |
| y_out | output | 1 | Mealy output: 1 when the state is nonzero and x_in is 0 |
| state_out | output | 2 | Present state; bit 1 is the high state bit, bit 0 the low one |

## Verification
There is one register between x_in and state_out. A new state is therefore due one rising edge after the input is applied. The bench drives x_in on the falling edge and reads state_out at the next falling edge. y_out is combinational, so it is due in the same cycle: the bench reads it a time step after changing x_in, with no clock edge in between. It also toggles x_in inside one clock phase to show that the output follows at once. Reset release is due SYNC_STAGES edges after rst_n rises, and the bench counts those edges before it expects the state to move.

// File: rtl/mealy2_pkg.sv
package mealy2_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ONE   = 2'b01,
    ST_PARK  = 2'b10,
    ST_CLIMB = 2'b11
  } mealy2_state_e;
endpackage

// File: rtl/mealy2_rst_sync.sv
module mealy2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mealy2_next.sv
module mealy2_next
  import mealy2_pkg::*;
(
  input  mealy2_state_e cur_state,
  input  logic          x_bit,
  output mealy2_state_e nxt_state
);
  always_comb begin
    nxt_state = ST_IDLE;
    if (x_bit) begin
      unique case (cur_state)
        ST_IDLE:  nxt_state = ST_ONE;
        ST_ONE:   nxt_state = ST_CLIMB;
        ST_PARK:  nxt_state = ST_PARK;
        ST_CLIMB: nxt_state = ST_PARK;
        default:  nxt_state = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mealy2_out.sv
module mealy2_out
  import mealy2_pkg::*;
(
  input  mealy2_state_e cur_state,
  input  logic          x_bit,
  output logic          y_bit
);
  always_comb begin
    y_bit = 1'b0;
    if (!x_bit && (cur_state != ST_IDLE)) y_bit = 1'b1;
  end
endmodule

// File: rtl/mealy2_fsm.sv
module mealy2_fsm
  import mealy2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               x_in,
  output logic               y_out,
  output logic [STATE_W-1:0] state_out
);
  logic          rst_int_n;
  mealy2_state_e state_q;
  mealy2_state_e state_d;

  mealy2_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mealy2_next u_next (
    .cur_state (state_q),
    .x_bit     (x_in),
    .nxt_state (state_d)
  );

  mealy2_out u_out (
    .cur_state (state_q),
    .x_bit     (x_in),
    .y_bit     (y_out)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  assign state_out = state_q;

  // R2
  a_r2_zero_input_home: assert property (@(posedge clk) disable iff (!rst_int_n)
    !x_in |=> state_out == 2'b00);
  // R3
  a_r3_idle_to_one: assert property (@(posedge clk) disable iff (!rst_int_n)
    (x_in && state_out == 2'b00) |=> state_out == 2'b01);
  // R4
  a_r4_one_to_climb: assert property (@(posedge clk) disable iff (!rst_int_n)
    (x_in && state_out == 2'b01) |=> state_out == 2'b11);
  // R5
  a_r5_upper_parks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (x_in && state_out[1]) |=> state_out == 2'b10);
  // R6
  a_r6_one_input_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    x_in |-> !y_out);
  // R7
  a_r7_break_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!x_in && state_out != 2'b00) |-> y_out);
  // R1
  a_r1_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> state_out == 2'b00);
endmodule

// File: tb/tb_mealy2_fsm.sv
module tb_mealy2_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       x_in;
  logic       y_out;
  logic [1:0] state_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mealy2_fsm #(.SYNC_STAGES(SYNC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_in      (x_in),
    .y_out     (y_out),
    .state_out (state_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x);
    if (!x) return 2'b00;
    case (s)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic ref_y(input logic [1:0] s, input logic x);
    return (!x) && (s != 2'b00);
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drives x on the falling edge, checks y at once, then checks the state one edge later.
  task automatic step(input logic x, input string req);
    logic [1:0] s;
    s = state_out;
    x_in = x;
    #1;
    chk(x ? "R6" : "R7", {1'b0, y_out}, {1'b0, ref_y(s, x)});
    @(negedge clk);
    chk(req, state_out, ref_next(s, x));
  endtask

  task automatic reach(input logic [1:0] s);
    step(1'b0, "R2");
    case (s)
      2'b01: step(1'b1, "R3");
      2'b11: begin step(1'b1, "R3"); step(1'b1, "R4"); end
      2'b10: begin step(1'b1, "R3"); step(1'b1, "R4"); step(1'b1, "R5"); end
      default: ;
    endcase
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    x_in = 1'b1;
    #1;
    chk("R1", state_out, 2'b00);
    @(negedge clk);
    chk("R1", state_out, 2'b00);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk);
      chk("R1", state_out, 2'b00);
    end
    @(negedge clk);
    chk("R3", state_out, 2'b01);
  endtask

  task automatic t_zero_input();
    for (int s = 0; s < 4; s++) begin
      reach(s[1:0]);
      chk("R2 setup", state_out, s[1:0]);
      step(1'b0, "R2");
    end
  endtask

  task automatic t_one_input();
    for (int s = 0; s < 4; s++) begin
      reach(s[1:0]);
      step(1'b1, s == 0 ? "R3" : (s == 1 ? "R4" : "R5"));
    end
    reach(2'b10);
    step(1'b1, "R5");
    step(1'b1, "R5");
  endtask

  task automatic t_comb_output();
    reach(2'b11);
    x_in = 1'b0;
    #1;
    chk("R8", {1'b0, y_out}, 2'b01);
    x_in = 1'b1;
    #1;
    chk("R8", {1'b0, y_out}, 2'b00);
    x_in = 1'b0;
    #1;
    chk("R8", {1'b0, y_out}, 2'b01);
    chk("R8", state_out, 2'b11);
    @(negedge clk);
  endtask

  task automatic t_async_reset();
    reach(2'b11);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1", state_out, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    x_in = 1'b1;
    for (int i = 0; i < SYNC; i++) @(negedge clk);
    chk("R1", state_out, 2'b00);
    @(negedge clk);
    chk("R3", state_out, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    x_in = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_input();
    t_one_input();
    t_comb_output();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule